// File: doc/BRIEF.md
# Disk Array Strip Locator with Row Parity Accumulator

This block places logical strips onto a five-disk array. A strip number and a layout selector are presented together with a valid strobe. One cycle later the block reports three things: the disk that holds the strip, the row (stripe) on that disk, and the disk that holds the parity for that row. Three layouts are available. In the first, strips are spread round robin with no parity. In the second, one fixed disk carries all parity. In the third, the parity position rotates from row to row.

A separate port builds the parity of a row. A row-start pulse clears it. Each data word presented afterwards is XOR-folded into the running value, and a ready flag rises once the row's four data words have been absorbed. Division and remainder by four and by five come from shifts and a reciprocal multiply, not from a general divider.

Top module: `array_strip_map`

## Requirements
- R1: `out_valid` is high in exactly the cycle after each cycle with `in_valid` high, and low otherwise. The mapping outputs update only on an accepted request and hold their values in between.
- R2: With `in_mode` = 0 (striping), `out_disk` = s mod 5, `out_row` = s div 5 and `out_parity_disk` = 0.
- R3: With `in_mode` = 1 (fixed parity disk), `out_disk` = s mod 4, `out_row` = s div 4 and `out_parity_disk` = 4.
- R4: With `in_mode` = 2 (rotating parity), `out_row` = s div 4 and `out_parity_disk` = 4 − (row mod 5). Across rows 0, 1, 2, 3, 4 this gives disks 4, 3, 2, 1, 0, and the pattern then repeats.
- R5: With `in_mode` = 2, the four data strips of a row take the non-parity disks in ascending order. With p = s mod 4, the disk is p when p is below the parity disk and p+1 otherwise.
- R6: With `in_mode` = 3, `out_mode_err` is 1 alongside `out_valid`, and `out_disk`, `out_row` and `out_parity_disk` are 0. For modes 0 to 2, `out_mode_err` is 0.
- R7: `parity_word` is the XOR of the words accepted since the last `start_row`. A `start_row` in the same cycle as `word_valid` restarts the row with that word alone.
- R8: `parity_ready` rises in the cycle after the fourth word of a row and stays high until the next `start_row`. Words offered after the fourth do not change `parity_word`.
- R9: With `rst_n` low at a clock edge, every registered output goes to 0.
- R10: The mapping is exact over the full 16-bit strip range, including strip 65535.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Mapping request strobe |
| in_strip | input | 16 | Logical strip number |
| in_mode | input | 2 | Layout: 0 stripe, 1 fixed parity, 2 rotating parity, 3 reserved |
| out_valid | output | 1 | Mapping result valid |
| out_disk | output | 3 | Disk holding the strip |
| out_row | output | 16 | Row (stripe) index |
| out_parity_disk | output | 3 | Disk holding the parity of that row |
| out_mode_err | output | 1 | Reserved mode was requested |
| start_row | input | 1 | Clear the parity accumulator |
| word_valid | input | 1 | Data word strobe |
| word_data | input | 32 | Data word of the current row |
| parity_word | output | 32 | Running XOR of the row |
| parity_ready | output | 1 | Four words absorbed |

## Verification
The assertions assume that `in_valid`, `in_mode`, `start_row` and `word_valid` are never unknown after reset. They also assume that a row's words follow a `start_row`. The bench raises `start_row` before each group of words and drives every input to a known value from time zero. The bench changes inputs only at the falling edge, so each request is captured at a single rising edge, and it adds idle cycles between bursts so that the holding behaviour can be observed.

// File: rtl/strip_map_pkg.sv
package strip_map_pkg;
  localparam int NUM_DISKS = 5;
  localparam int DISK_W    = 3;
  localparam int STRIP_W   = 16;
  localparam int ROW_W     = 16;

  typedef enum logic [1:0] {
    LAY_STRIPE = 2'd0,
    LAY_FIXED  = 2'd1,
    LAY_ROTATE = 2'd2,
    LAY_RSVD   = 2'd3
  } layout_t;

  // quotient by five: multiply by ceil(2^18/5) and shift, exact for 16 bits
  function automatic logic [15:0] div_by5(input logic [15:0] x);
    logic [31:0] prod;
    prod = 32'(x) * 32'd52429;
    return {2'b00, prod[31:18]};
  endfunction

  function automatic logic [2:0] mod_by5(input logic [15:0] x);
    logic [15:0] rem;
    rem = x - (div_by5(x) * 16'd5);
    return rem[2:0];
  endfunction
endpackage

// File: rtl/sm_locator.sv
module sm_locator
  import strip_map_pkg::*;
(
  input  logic [STRIP_W-1:0] strip,
  input  logic [1:0]         mode,
  output logic [DISK_W-1:0]  disk,
  output logic [ROW_W-1:0]   row,
  output logic [DISK_W-1:0]  pdisk,
  output logic               bad_mode
);
  logic [ROW_W-1:0]  row_by4;
  logic [DISK_W-1:0] slot;
  logic [DISK_W-1:0] rot_pdisk;

  assign row_by4   = {2'b00, strip[STRIP_W-1:2]};
  assign slot      = {1'b0, strip[1:0]};
  assign rot_pdisk = 3'd4 - mod_by5(row_by4);

  always_comb begin
    disk     = '0;
    row      = '0;
    pdisk    = '0;
    bad_mode = 1'b0;
    unique case (layout_t'(mode))
      LAY_STRIPE: begin
        disk = mod_by5(strip);
        row  = div_by5(strip);
      end
      LAY_FIXED: begin
        disk  = slot;
        row   = row_by4;
        pdisk = 3'(NUM_DISKS - 1);
      end
      LAY_ROTATE: begin
        row   = row_by4;
        pdisk = rot_pdisk;
        disk  = (slot < rot_pdisk) ? slot : slot + 3'd1;
      end
      default: bad_mode = 1'b1;
    endcase
  end
endmodule

// File: rtl/sm_parity_acc.sv
module sm_parity_acc #(
  parameter int DATA_W = 32,
  parameter int WORDS  = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start_row,
  input  logic              word_valid,
  input  logic [DATA_W-1:0] word_data,
  output logic [DATA_W-1:0] parity_word,
  output logic              parity_ready
);
  localparam int CNT_W = $clog2(WORDS + 1);

  logic [CNT_W-1:0] cnt;
  logic             take;
  logic             row_full;

  assign row_full = (cnt == CNT_W'(WORDS));
  assign take     = word_valid && (start_row || !row_full);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      parity_word  <= '0;
      cnt          <= '0;
      parity_ready <= 1'b0;
    end else if (start_row) begin
      parity_word  <= word_valid ? word_data : '0;
      cnt          <= word_valid ? CNT_W'(1) : '0;
      parity_ready <= word_valid && (WORDS == 1);
    end else if (take) begin
      parity_word  <= parity_word ^ word_data;
      cnt          <= cnt + CNT_W'(1);
      parity_ready <= (cnt == CNT_W'(WORDS - 1));
    end
  end

  AST_READY_FULL: assert property (@(posedge clk) disable iff (!rst_n)
    parity_ready |-> row_full); // R8
  AST_CLEAR_ROW: assert property (@(posedge clk) disable iff (!rst_n)
    start_row && !word_valid |=> parity_word == '0 && !parity_ready); // R7
  AST_HOLD_FULL: assert property (@(posedge clk) disable iff (!rst_n)
    parity_ready && !start_row |=> $stable(parity_word) && parity_ready); // R8
endmodule

// File: rtl/array_strip_map.sv
module array_strip_map
  import strip_map_pkg::*;
#(
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  input  logic [15:0]       in_strip,
  input  logic [1:0]        in_mode,
  output logic              out_valid,
  output logic [2:0]        out_disk,
  output logic [15:0]       out_row,
  output logic [2:0]        out_parity_disk,
  output logic              out_mode_err,
  input  logic              start_row,
  input  logic              word_valid,
  input  logic [DATA_W-1:0] word_data,
  output logic [DATA_W-1:0] parity_word,
  output logic              parity_ready
);
  localparam int WORDS_PER_ROW = NUM_DISKS - 1;

  logic [DISK_W-1:0] loc_disk, loc_pdisk;
  logic [ROW_W-1:0]  loc_row;
  logic              loc_bad;
  logic [1:0]        mode_q;

  sm_locator u_loc (
    .strip    (in_strip),
    .mode     (in_mode),
    .disk     (loc_disk),
    .row      (loc_row),
    .pdisk    (loc_pdisk),
    .bad_mode (loc_bad)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      out_valid       <= 1'b0;
      out_disk        <= '0;
      out_row         <= '0;
      out_parity_disk <= '0;
      out_mode_err    <= 1'b0;
      mode_q          <= '0;
    end else begin
      out_valid <= in_valid;
      if (in_valid) begin
        out_disk        <= loc_disk;
        out_row         <= loc_row;
        out_parity_disk <= loc_pdisk;
        out_mode_err    <= loc_bad;
        mode_q          <= in_mode;
      end
    end
  end

  sm_parity_acc #(.DATA_W(DATA_W), .WORDS(WORDS_PER_ROW)) u_acc (
    .clk          (clk),
    .rst_n        (rst_n),
    .start_row    (start_row),
    .word_valid   (word_valid),
    .word_data    (word_data),
    .parity_word  (parity_word),
    .parity_ready (parity_ready)
  );

  AST_VALID_LATENCY: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid |=> out_valid); // R1
  AST_VALID_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> !out_valid && $stable(out_disk) && $stable(out_row)); // R1
  AST_DISK_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> out_disk < 3'(NUM_DISKS)); // R2
  AST_FIXED_PARITY: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && mode_q == LAY_FIXED |-> out_parity_disk == 3'd4 && out_disk != 3'd4); // R3
  AST_DATA_OFF_PARITY: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && mode_q == LAY_ROTATE |-> out_disk != out_parity_disk); // R5
  AST_ERR_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && out_mode_err |-> out_disk == '0 && out_row == '0 && out_parity_disk == '0); // R6
endmodule

// File: tb/sim_array_strip_map.sv
module sim_array_strip_map;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        in_valid = 1'b0;
  logic [15:0] in_strip = '0;
  logic [1:0]  in_mode = '0;
  logic        out_valid, out_mode_err, parity_ready;
  logic [2:0]  out_disk, out_parity_disk;
  logic [15:0] out_row;
  logic        start_row = 1'b0, word_valid = 1'b0;
  logic [31:0] word_data = '0;
  logic [31:0] parity_word;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  array_strip_map u0 (.*);

  task automatic check(input string req, input longint act, input longint exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // independent reference for one request
  task automatic ref_map(input int s, input int m, output int d, output int r,
                         output int p, output int e);
    d = 0; r = 0; p = 0; e = 0;
    case (m)
      0: begin d = s % 5; r = s / 5; end
      1: begin d = s % 4; r = s / 4; p = 4; end
      2: begin
        r = s / 4;
        p = 4 - (r % 5);
        d = ((s % 4) < p) ? (s % 4) : (s % 4) + 1;
      end
      default: e = 1;
    endcase
  endtask

  task automatic map_one(input int s, input int m, input string req);
    int d, r, p, e;
    in_valid = 1'b1; in_strip = 16'(s); in_mode = 2'(m);
    @(negedge clk);
    in_valid = 1'b0;
    ref_map(s, m, d, r, p, e);
    check({req, " valid"}, out_valid, 1);
    check({req, " disk"}, out_disk, d);
    check({req, " row"}, out_row, r);
    check({req, " pdisk"}, out_parity_disk, p);
    check({req, " err"}, out_mode_err, e);
  endtask

  task automatic push_word(input logic [31:0] w, input logic st);
    word_valid = 1'b1; word_data = w; start_row = st;
    @(negedge clk);
    word_valid = 1'b0; start_row = 1'b0;
  endtask

  initial begin
    logic [31:0] x;
    logic [2:0]  hold_d;
    @(negedge clk);
    @(negedge clk);
    // R9: reset state
    check("R9 out_valid", out_valid, 0);
    check("R9 out_row", out_row, 0);
    check("R9 parity_word", parity_word, 0);
    check("R9 parity_ready", parity_ready, 0);
    rst_n = 1'b1;
    @(negedge clk);

    // R2 R3 R4 R5: every strip 0..99 in each layout
    for (int m = 0; m < 3; m++)
      for (int s = 0; s < 100; s++)
        map_one(s, m, m == 0 ? "R2" : (m == 1 ? "R3" : "R4/R5"));

    // R1: idle cycle holds outputs and drops valid
    hold_d = out_disk;
    @(negedge clk);
    check("R1 idle valid", out_valid, 0);
    check("R1 hold disk", out_disk, hold_d);

    // R6: reserved layout
    map_one(57, 3, "R6");
    map_one(21, 2, "R6 clear");

    // R10: top of range
    for (int m = 0; m < 3; m++) begin
      map_one(65535, m, "R10");
      map_one(65534, m, "R10");
      map_one(40000, m, "R10");
    end

    // R7 R8: parity accumulation
    x = 0;
    start_row = 1'b1; @(negedge clk); start_row = 1'b0;
    check("R7 clear", parity_word, 0);
    for (int i = 0; i < 4; i++) begin
      logic [31:0] w;
      w = 32'h1357_9bdf * (i + 3) ^ 32'(i << 20);
      x = x ^ w;
      push_word(w, 1'b0);
      check("R8 ready timing", parity_ready, i == 3);
      check("R7 running xor", parity_word, x);
    end
    push_word(32'hdead_beef, 1'b0);
    check("R8 extra ignored", parity_word, x);
    check("R8 ready held", parity_ready, 1);
    push_word(32'h0f0f_0000, 1'b1);
    check("R7 start with word", parity_word, 32'h0f0f_0000);
    check("R8 ready dropped", parity_ready, 0);

    // R9: reset in mid-use
    map_one(9, 2, "R9 pre");
    rst_n = 1'b0; @(negedge clk);
    check("R9 disk cleared", out_disk, 0);
    check("R9 parity cleared", parity_word, 0);
    rst_n = 1'b1;
    done = 1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (20000) @(posedge clk);
        errors++;
        checks++;
        $display("FAIL watchdog actual=timeout expected=completion");
      end
    join_any
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule